// File: doc/BRIEF.md
# Dual-Processor Mailbox Bridge

The bridge carries bytes between a host processor and a parasite processor that share one clock. Each side sees four numbered mailbox registers. Every number stands for two independent byte channels. The "downward" channel is written by the host and read by the parasite. The "upward" channel is written by the parasite and read by the host. Each side reads a status byte per register, which tells its reader that data is waiting and tells its writer that there is room.

The channels do not all buffer the same amount. Register 1 upward is a deep FIFO (24 bytes by default), while register 1 downward is a single-byte holding register. Register 3 is a two-entry FIFO in both directions. Registers 2 and 4 are single-byte holding registers in both directions.

The host side has a chip select, a three-bit offset, a read/not-write line and byte data. The parasite side is an 8-bit I/O port with active-low read and write strobes. It responds only during I/O cycles, recognised from its I/O-request and opcode-fetch signals. Toward the parasite the bridge drives three outputs:
- a level interrupt, raised while register 1 or register 4 holds downward data;
- a one-cycle non-maskable pulse, raised after each host write to register 3;
- a reset, controlled by the host.

Every cycle in which a side's strobe is active counts as one access.

Top module: `mbx_bridge`

## Requirements
- R1: After reset every status byte reads 0x40 on both sides, p_irq, p_nmi and p_rst are low, and an unwritten data register reads 0x00.
- R2: Register 1 upward is a FIFO of R1_UP_DEPTH bytes (24 by default). Bytes come out in write order, and a parasite write to it when it is full is dropped.
- R3: Register 1 downward holds one byte. A second host write is dropped until the parasite has read the first.
- R4: Register 3 is a FIFO of R3_DEPTH bytes (2 by default) in each direction. Writes beyond that depth are dropped.
- R5: Registers 2 and 4 hold one byte in each direction. A write to an occupied one is dropped, and the stored byte is kept.
- R6: Offset bit 0 chooses data (1) or status (0), and offset bits 2:1 give the register number minus one. On the parasite port, address bits 7:3 are ignored, so the map repeats every 8 addresses across all 256.
- R7: The parasite port reads or writes only when p_iorq_n is 0 and p_m1_n is 1. Otherwise its strobes have no effect and no byte is removed.
- R8: p_irq is high while register 1 downward or register 4 downward holds an unread byte.
- R9: p_nmi is high for exactly the one cycle after a host write to the data offset of register 3.
- R10: A host write to offset 0 sets p_rst to bit 0 of the written byte. After bit 0 is cleared, p_rst stays high for one further cycle. Every cycle with p_rst high empties all channels, and writes in such a cycle are dropped.
- R11: Reading an empty FIFO returns the byte most recently removed from it and leaves its pointers unchanged.
- R12: In a status byte, bit 7 means a byte is waiting for this side to read, and bit 6 means this side may write. Bits 5:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_cs | input | 1 | Host access strobe, one cycle per access |
| h_rnw | input | 1 | Host read (1) or write (0) |
| h_addr | input | 3 | Host register offset |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte, combinational |
| p_iorq_n | input | 1 | Parasite I/O request, active low |
| p_m1_n | input | 1 | Parasite opcode-fetch cycle, active low |
| p_rd_n | input | 1 | Parasite read strobe, active low |
| p_wr_n | input | 1 | Parasite write strobe, active low |
| p_addr | input | 8 | Parasite I/O address |
| p_wdata | input | 8 | Parasite write byte |
| p_rdata | output | 8 | Parasite read byte, combinational |
| p_irq | output | 1 | Interrupt request toward the parasite |
| p_nmi | output | 1 | Non-maskable interrupt pulse |
| p_rst | output | 1 | Reset toward the parasite |

## Verification
A pointer or count error in the deep upward FIFO shows up first in the host status byte. The waiting bit or the room bit flips at the wrong fill level, and this is visible within one cycle of the access that caused it. Later reads would then return bytes out of order or repeat them. A holding register that accepts an overwrite shows the second byte on the next read from the other side. A stuck interrupt source keeps p_irq high after that read. A reset whose flush fails leaves a status waiting bit set once p_rst has fallen.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int BYTE_W     = 8;
   localparam int NUM_REGS   = 4;
   localparam int MAX_DEPTH  = 255;
   localparam int ST_AVAIL   = 7;
   localparam int ST_ROOM    = 6;
   localparam int NMI_REG    = 2;
   localparam logic [NUM_REGS-1:0] IRQ_SRC_MASK = 4'b1001;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [7:0]        lvl_t;

   function automatic int up_depth(input int idx, input int r1d, input int r3d);
      case (idx)
         0:       return r1d;
         2:       return r3d;
         default: return 1;
      endcase
   endfunction

   function automatic int dn_depth(input int idx, input int r3d);
      return (idx == 2) ? r3d : 1;
   endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo import mbx_pkg::*; #(
   parameter int DEPTH = 2,
   parameter int W     = BYTE_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         avail,
   output logic         room,
   output lvl_t         level
);
   if (DEPTH < 1 || DEPTH > MAX_DEPTH) begin : g_bad_depth
      $error("mbx_fifo: DEPTH out of range");
   end
   if (W < 1) begin : g_bad_width
      $error("mbx_fifo: W must be positive");
   end

   if (DEPTH == 1) begin : g_hold
      logic         full_q;
      logic [W-1:0] data_q;
      logic         take;

      assign take = push && !full_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
         end else if (flush) begin
            full_q <= 1'b0;
         end else begin
            if (take) begin
               full_q <= 1'b1;
               data_q <= din;
            end else if (pop && full_q) begin
               full_q <= 1'b0;
            end
         end
      end

      assign dout  = data_q;
      assign avail = full_q;
      assign room  = !full_q;
      assign level = lvl_t'(full_q);
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

      logic [W-1:0]  mem [DEPTH];
      logic [PW-1:0] wp_q, rp_q;
      lvl_t          cnt_q;
      logic [W-1:0]  last_q;
      logic          take, give;

      function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
         return (p == LAST_IDX) ? '0 : p + 1'b1;
      endfunction

      assign take = push && (cnt_q < lvl_t'(DEPTH));
      assign give = pop && (cnt_q != '0);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            last_q <= '0;
         end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (take) wp_q <= step(wp_q);
            if (give) begin
               rp_q   <= step(rp_q);
               last_q <= mem[rp_q];
            end
            cnt_q <= cnt_q + lvl_t'(take) - lvl_t'(give);
         end
      end

      always_ff @(posedge clk) begin
         if (!flush && take) mem[wp_q] <= din;
      end

      assign dout  = (cnt_q != '0) ? mem[rp_q] : last_q;
      assign avail = (cnt_q != '0);
      assign room  = (cnt_q < lvl_t'(DEPTH));
      assign level = cnt_q;
   end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl import mbx_pkg::*; #(
   parameter int                  NREG       = NUM_REGS,
   parameter logic [NREG-1:0]     IRQ_MASK   = IRQ_SRC_MASK,
   parameter int                  HOLD_CYC   = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_we,
   input  logic            ctl_bit,
   input  logic            nmi_trig,
   input  logic [NREG-1:0] dn_avail,
   output logic            p_irq,
   output logic            p_nmi,
   output logic            p_rst
);
   localparam int HW = $clog2(HOLD_CYC + 1);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("mbx_ctrl: HOLD_CYC must be at least 1");
   end

   logic          ctl_q;
   logic [HW-1:0] hold_q;
   logic          nmi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= 1'b0;
         hold_q <= '0;
         nmi_q  <= 1'b0;
      end else begin
         if (ctl_we) ctl_q <= ctl_bit;
         if (ctl_q)               hold_q <= HW'(HOLD_CYC);
         else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
         nmi_q <= nmi_trig;
      end
   end

   assign p_rst = ctl_q || (hold_q != '0);
   assign p_nmi = nmi_q;

   if (IRQ_MASK == '0) begin : g_no_irq
      assign p_irq = 1'b0;
   end else begin : g_irq
      assign p_irq = |(dn_avail & IRQ_MASK);
   end
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge import mbx_pkg::*; #(
   parameter int R1_UP_DEPTH = 24,
   parameter int R3_DEPTH    = 2,
   parameter int RST_HOLD    = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       h_cs,
   input  logic       h_rnw,
   input  logic [2:0] h_addr,
   input  logic [7:0] h_wdata,
   output logic [7:0] h_rdata,
   input  logic       p_iorq_n,
   input  logic       p_m1_n,
   input  logic       p_rd_n,
   input  logic       p_wr_n,
   input  logic [7:0] p_addr,
   input  logic [7:0] p_wdata,
   output logic [7:0] p_rdata,
   output logic       p_irq,
   output logic       p_nmi,
   output logic       p_rst
);
   localparam int IW = $clog2(NUM_REGS);

   if (R1_UP_DEPTH < 1 || R1_UP_DEPTH > MAX_DEPTH) begin : g_bad_r1
      $error("mbx_bridge: R1_UP_DEPTH out of range");
   end
   if (R3_DEPTH < 1 || R3_DEPTH > MAX_DEPTH) begin : g_bad_r3
      $error("mbx_bridge: R3_DEPTH out of range");
   end

   // decode
   logic          h_rd, h_wr, h_dat;
   logic [IW-1:0] h_idx;
   logic          p_sel, p_rd, p_wr, p_dat;
   logic [IW-1:0] p_idx;
   logic          unused_p_addr_hi;

   assign h_rd  = h_cs && h_rnw;
   assign h_wr  = h_cs && !h_rnw;
   assign h_dat = h_addr[0];
   assign h_idx = h_addr[2:1];

   assign p_sel = !(p_iorq_n || !p_m1_n);
   assign p_rd  = p_sel && !p_rd_n;
   assign p_wr  = p_sel && !p_wr_n;
   assign p_dat = p_addr[0];
   assign p_idx = p_addr[2:1];
   assign unused_p_addr_hi = ^p_addr[7:3];

   logic [NUM_REGS-1:0]        up_av, up_rm, dn_av, dn_rm;
   logic [NUM_REGS-1:0][7:0]   up_q, dn_q;
   logic [NUM_REGS-1:0][7:0]   up_lvl, dn_lvl;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam int UPD = up_depth(g, R1_UP_DEPTH, R3_DEPTH);
      localparam int DND = dn_depth(g, R3_DEPTH);

      mbx_fifo #(.DEPTH(UPD), .W(BYTE_W)) u_up (
         .clk   (clk),
         .rst_n (rst_n),
         .flush (p_rst),
         .push  (p_wr && p_dat && (p_idx == IW'(g))),
         .din   (p_wdata),
         .pop   (h_rd && h_dat && (h_idx == IW'(g))),
         .dout  (up_q[g]),
         .avail (up_av[g]),
         .room  (up_rm[g]),
         .level (up_lvl[g])
      );

      mbx_fifo #(.DEPTH(DND), .W(BYTE_W)) u_dn (
         .clk   (clk),
         .rst_n (rst_n),
         .flush (p_rst),
         .push  (h_wr && h_dat && (h_idx == IW'(g))),
         .din   (h_wdata),
         .pop   (p_rd && p_dat && (p_idx == IW'(g))),
         .dout  (dn_q[g]),
         .avail (dn_av[g]),
         .room  (dn_rm[g]),
         .level (dn_lvl[g])
      );
   end

   // read muxes
   always_comb begin
      h_rdata = '0;
      if (h_dat) begin
         h_rdata = up_q[h_idx];
      end else begin
         h_rdata[ST_AVAIL] = up_av[h_idx];
         h_rdata[ST_ROOM]  = dn_rm[h_idx];
      end
   end

   always_comb begin
      p_rdata = '0;
      if (p_dat) begin
         p_rdata = dn_q[p_idx];
      end else begin
         p_rdata[ST_AVAIL] = dn_av[p_idx];
         p_rdata[ST_ROOM]  = up_rm[p_idx];
      end
   end

   mbx_ctrl #(.NREG(NUM_REGS), .IRQ_MASK(IRQ_SRC_MASK), .HOLD_CYC(RST_HOLD)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (h_wr && (h_addr == 3'd0)),
      .ctl_bit  (h_wdata[0]),
      .nmi_trig (h_wr && h_dat && (h_idx == IW'(NMI_REG))),
      .dn_avail (dn_av),
      .p_irq    (p_irq),
      .p_nmi    (p_nmi),
      .p_rst    (p_rst)
   );
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk import mbx_pkg::*; #(
   parameter int R1_UP_DEPTH = 24,
   parameter int R3_DEPTH    = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      h_cs,
   input logic                      h_rnw,
   input logic [2:0]                h_addr,
   input logic                      h_ctl_bit,
   input logic                      p_iorq_n,
   input logic                      p_irq,
   input logic                      p_nmi,
   input logic                      p_rst,
   input logic [NUM_REGS-1:0][7:0]  up_lvl,
   input logic [NUM_REGS-1:0][7:0]  dn_lvl
);
   logic h_wr;
   assign h_wr = h_cs && !h_rnw;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_lvl
      AST_NO_OVERFLOW_UP: assert property (@(posedge clk) disable iff (!rst_n)
         int'(up_lvl[g]) <= up_depth(g, R1_UP_DEPTH, R3_DEPTH)); // R2
      AST_NO_OVERFLOW_DN: assert property (@(posedge clk) disable iff (!rst_n)
         int'(dn_lvl[g]) <= dn_depth(g, R3_DEPTH)); // R4
      AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         !p_rst |=> (up_lvl[g] == $past(up_lvl[g])) || (up_lvl[g] == $past(up_lvl[g]) + 8'd1)
                    || (up_lvl[g] + 8'd1 == $past(up_lvl[g]))); // R11
   end

   AST_IRQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && !p_rst && p_iorq_n && (h_addr == 3'd1 || h_addr == 3'd7)) |=> p_irq); // R8
   AST_NMI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && h_addr == 3'd5) |=> p_nmi); // R9
   AST_NMI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(h_wr && h_addr == 3'd5) |=> !p_nmi); // R9
   AST_RST_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && h_addr == 3'd0 && h_ctl_bit) |=> p_rst); // R10
   AST_RST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(p_rst) |-> $past(p_rst, 2)); // R10
   AST_RST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      p_rst |=> !p_irq); // R10
endmodule

bind mbx_bridge mbx_bridge_chk #(.R1_UP_DEPTH(R1_UP_DEPTH), .R3_DEPTH(R3_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .h_cs      (h_cs),
   .h_rnw     (h_rnw),
   .h_addr    (h_addr),
   .h_ctl_bit (h_wdata[0]),
   .p_iorq_n  (p_iorq_n),
   .p_irq     (p_irq),
   .p_nmi     (p_nmi),
   .p_rst     (p_rst),
   .up_lvl    (up_lvl),
   .dn_lvl    (dn_lvl)
);

// File: tb/mbx_bridge_bench.sv
module mbx_bridge_bench;
   localparam int R1D = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       h_cs = 1'b0, h_rnw = 1'b1;
   logic [2:0] h_addr = '0;
   logic [7:0] h_wdata = '0;
   logic [7:0] h_rdata;
   logic       p_iorq_n = 1'b1, p_m1_n = 1'b1, p_rd_n = 1'b1, p_wr_n = 1'b1;
   logic [7:0] p_addr = '0, p_wdata = '0;
   logic [7:0] p_rdata;
   logic       p_irq, p_nmi, p_rst;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mbx_bridge #(.R1_UP_DEPTH(R1D), .R3_DEPTH(2)) u_mbx_bridge (
      .clk(clk), .rst_n(rst_n),
      .h_cs(h_cs), .h_rnw(h_rnw), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
      .p_iorq_n(p_iorq_n), .p_m1_n(p_m1_n), .p_rd_n(p_rd_n), .p_wr_n(p_wr_n),
      .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
      .p_irq(p_irq), .p_nmi(p_nmi), .p_rst(p_rst)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // host access: drive at falling edge, sample read data, commit at rising edge
   task automatic h_acc(input bit rnw, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] q);
      @(negedge clk);
      h_cs = 1'b1; h_rnw = rnw; h_addr = a; h_wdata = d;
      #1 q = h_rdata;
      @(posedge clk);
      #1 h_cs = 1'b0; h_rnw = 1'b1;
   endtask

   task automatic p_acc(input bit rnw, input logic [7:0] a, input logic [7:0] d,
                        input bit iorq_n, input bit m1_n, output logic [7:0] q);
      @(negedge clk);
      p_iorq_n = iorq_n; p_m1_n = m1_n; p_addr = a; p_wdata = d;
      p_rd_n = !rnw; p_wr_n = rnw;
      #1 q = p_rdata;
      @(posedge clk);
      #1 p_iorq_n = 1'b1; p_m1_n = 1'b1; p_rd_n = 1'b1; p_wr_n = 1'b1;
   endtask

   task automatic hw(input logic [2:0] a, input logic [7:0] d);
      logic [7:0] q;
      h_acc(1'b0, a, d, q);
   endtask
   task automatic hr(input logic [2:0] a, output logic [7:0] q);
      h_acc(1'b1, a, 8'h00, q);
   endtask
   task automatic pw(input logic [7:0] a, input logic [7:0] d);
      logic [7:0] q;
      p_acc(1'b0, a, d, 1'b0, 1'b1, q);
   endtask
   task automatic pr(input logic [7:0] a, output logic [7:0] q);
      p_acc(1'b1, a, 8'h00, 1'b0, 1'b1, q);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] q;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1, R12: reset state
      for (int k = 0; k < 4; k++) begin
         hr(3'(2*k), q);        chk("R1 host status", q, 8'h40);
         pr(8'(2*k), q);        chk("R1 parasite status", q, 8'h40);
      end
      hr(3'd1, q); chk("R1 empty data", q, 8'h00);
      chk("R1 irq", {7'b0, p_irq}, 8'h00);
      chk("R1 nmi", {7'b0, p_nmi}, 8'h00);
      chk("R1 rst", {7'b0, p_rst}, 8'h00);

      // R2, R6: fill upward register 1 with aliased addresses
      for (int i = 0; i < R1D; i++) begin
         pr(8'h00, q);
         chk("R12 p room before full", q, 8'h40);
         pw(8'(8*i + 1), 8'(i*7 + 3));
      end
      pr(8'hF8, q); chk("R2 p status full", q, 8'h00);
      pw(8'h01, 8'hEE);
      hr(3'd0, q); chk("R12 host status avail", q, 8'hC0);
      for (int i = 0; i < R1D; i++) begin
         hr(3'd1, q); chk("R2 fifo order", q, 8'(i*7 + 3));
      end
      hr(3'd0, q); chk("R2 drained", q, 8'h40);
      hr(3'd1, q); chk("R11 empty read last", q, 8'(23*7 + 3));
      hr(3'd0, q); chk("R11 no underflow", q, 8'h40);

      // R3, R8: downward register 1 latch
      hw(3'd1, 8'h5A);
      chk("R8 irq from reg1", {7'b0, p_irq}, 8'h01);
      hr(3'd0, q); chk("R3 host no room", q, 8'h00);
      hw(3'd1, 8'hA5);
      pr(8'h00, q); chk("R3 p status", q, 8'hC0);
      pr(8'h41, q); chk("R3 keeps first", q, 8'h5A);
      chk("R8 irq clears", {7'b0, p_irq}, 8'h00);
      pr(8'h01, q); chk("R3 empty holds", q, 8'h5A);

      // R4, R9: register 3 both ways
      hw(3'd5, 8'h31);
      chk("R9 nmi high", {7'b0, p_nmi}, 8'h01);
      @(posedge clk); #1;
      chk("R9 nmi one cycle", {7'b0, p_nmi}, 8'h00);
      hw(3'd5, 8'h32);
      hw(3'd5, 8'h33);
      hr(3'd4, q); chk("R4 down full", q, 8'h00);
      chk("R8 reg3 no irq", {7'b0, p_irq}, 8'h00);
      pr(8'h05, q); chk("R4 down first", q, 8'h31);
      pr(8'h05, q); chk("R4 down second", q, 8'h32);
      pr(8'h04, q); chk("R4 down empty", q, 8'h40);
      pw(8'h25, 8'h41); pw(8'h25, 8'h42); pw(8'h25, 8'h43);
      pr(8'h04, q); chk("R4 up full", q, 8'h00);
      hr(3'd5, q); chk("R4 up first", q, 8'h41);
      hr(3'd5, q); chk("R4 up second", q, 8'h42);
      hr(3'd4, q); chk("R4 up empty", q, 8'h40);

      // R5, R6, R8: latch sweep over registers 2 and 4
      for (int v = 0; v < 256; v += 17) begin
         logic [7:0] b;
         b = 8'(v);
         hw(3'd3, b);
         pr({b[7:3], 3'b011}, q); chk("R5 reg2 down", q, b);
         pw({b[7:3], 3'b011}, ~b);
         hr(3'd3, q); chk("R5 reg2 up", q, ~b);
         hw(3'd7, b ^ 8'h5C);
         chk("R8 irq from reg4", {7'b0, p_irq}, 8'h01);
         pr({~b[7:3], 3'b111}, q); chk("R5 reg4 down", q, b ^ 8'h5C);
         chk("R8 irq off", {7'b0, p_irq}, 8'h00);
         pw({b[7:3], 3'b111}, b + 8'd1);
         hr(3'd7, q); chk("R5 reg4 up", q, b + 8'd1);
      end
      hw(3'd3, 8'h11); hw(3'd3, 8'h22);
      pr(8'h03, q); chk("R5 overwrite dropped", q, 8'h11);

      // R7: strobes without a valid I/O cycle
      p_acc(1'b0, 8'h03, 8'h99, 1'b0, 1'b0, q);
      p_acc(1'b0, 8'h03, 8'h98, 1'b1, 1'b1, q);
      hr(3'd2, q); chk("R7 writes ignored", q, 8'h40);
      hw(3'd3, 8'h77);
      p_acc(1'b1, 8'h03, 8'h00, 1'b0, 1'b0, q);
      p_acc(1'b1, 8'h03, 8'h00, 1'b1, 1'b1, q);
      hr(3'd2, q); chk("R7 reads ignored", q, 8'h00);
      pr(8'h03, q); chk("R7 byte intact", q, 8'h77);

      // R10: reset control and flush
      pw(8'h01, 8'h10);
      hw(3'd7, 8'h20);
      chk("R10 irq before", {7'b0, p_irq}, 8'h01);
      hw(3'd0, 8'h01);
      chk("R10 rst set", {7'b0, p_rst}, 8'h01);
      @(posedge clk); #1;
      chk("R10 flush irq", {7'b0, p_irq}, 8'h00);
      hw(3'd0, 8'h00);
      chk("R10 rst held", {7'b0, p_rst}, 8'h01);
      @(posedge clk); #1;
      chk("R10 rst released", {7'b0, p_rst}, 8'h00);
      hr(3'd0, q); chk("R10 reg1 flushed", q, 8'h40);
      hr(3'd6, q); chk("R10 reg4 flushed", q, 8'h40);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule